// File: doc/BRIEF.md
# Descending Operand Stack with Dual Read

The block is a small hardware operand stack for a stack-oriented datapath. It keeps a fixed array of words and a pointer. A push stores a word and moves the pointer toward the top. A pop moves the pointer back toward the bottom. Index 15 is the bottom of the stack and index 0 is the top.

Two read ports are always live. One shows the word on the top of the stack. The other shows the word just beneath it. An arithmetic stage can therefore take both operands in a single cycle.

The pointer and the array both change on the falling clock edge. This leaves the rising edge free for the stages around the block. Reset moves only the pointer back to the bottom and leaves the stored words in place. The pointer has no overflow or underflow guard, so it wraps freely.

Top module: `opStack`

## Requirements
- R1: While `rstN` is low, the pointer is forced to the bottom index, DEPTH-1 (15 by default). Right after a reset, `topWord` shows entry 0 and `nextWord` shows entry 1, because the read indices wrap.
- R2: When `en`=1 and `dir`=1 (push), `dataIn` is written at the current pointer and the pointer then decrements by one. From the next falling edge, `topWord` equals the pushed word.
- R3: When `en`=1 and `dir`=0 (pop), the pointer increments by one. From the next falling edge, `topWord` equals the value `nextWord` had before that edge.
- R4: When `en`=0, `dir` and `dataIn` have no effect: the pointer, the array and both outputs keep their values.
- R5: `topWord` is entry pointer+1 and `nextWord` is entry pointer+2, both taken modulo DEPTH. Both are combinational and valid together.
- R6: Reset does not change any stored entry. Words written before a reset can still be read after it.
- R7: There is no overflow or underflow protection. The pointer wraps modulo DEPTH in both directions, and a push past the top overwrites the oldest entry.
- R8: Pointer and array updates happen only on the falling edge. Just after a rising edge, both outputs still hold the values set at the previous falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state updates on its falling edge |
| rstN | input | 1 | Asynchronous active-low reset of the pointer only |
| en | input | 1 | Operation enable |
| dir | input | 1 | 1 = push, 0 = pop |
| dataIn | input | WIDTH | Word to push |
| topWord | output | WIDTH | Entry at pointer+1 (top of stack) |
| nextWord | output | WIDTH | Entry at pointer+2 (below the top) |

## Verification
The driver applies each operation just after a rising edge. The result of that operation is due at the falling edge of the same cycle. A monitor samples both read ports two time units after that falling edge and checks them against the expectation queued by the driver. Before it changes the inputs, the driver also samples the outputs just after the rising edge. These samples must still match the previous expectation, which shows that nothing moves on the rising edge. Reset takes effect as soon as `rstN` falls, and it is checked at the falling edge that follows.

// File: rtl/opStackPkg.sv
package opStackPkg;
  typedef struct packed {
    logic pushEn;
    logic popEn;
  } stackCtrl_t;
endpackage

// File: rtl/opStackCtrl.sv
module opStackCtrl
  import opStackPkg::*;
(
  input  logic       en,
  input  logic       dir,
  output stackCtrl_t ctrl
);
  always_comb begin
    ctrl.pushEn = en & dir;
    ctrl.popEn  = en & ~dir;
  end
endmodule

// File: rtl/opStackDatapath.sv
module opStackDatapath
  import opStackPkg::*;
#(
  parameter int WIDTH = 16,
  parameter int PTR_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  stackCtrl_t       ctrl,
  input  logic [WIDTH-1:0] dataIn,
  output logic [WIDTH-1:0] topWord,
  output logic [WIDTH-1:0] nextWord
);
  localparam int DEPTH = 1 << PTR_W;
  localparam logic [PTR_W-1:0] BOTTOM = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] sp;
  logic [PTR_W-1:0] topIdx;
  logic [PTR_W-1:0] nextIdx;

  // Pointer: only state touched by reset (R1, R6)
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN)            sp <= BOTTOM;
    else if (ctrl.pushEn) sp <= sp - PTR_W'(1);
    else if (ctrl.popEn)  sp <= sp + PTR_W'(1);
  end

  // Storage: no reset, falling-edge write (R6, R8)
  always_ff @(negedge clk) begin
    if (ctrl.pushEn) mem[sp] <= dataIn;
  end

  always_comb begin
    topIdx  = sp + PTR_W'(1);
    nextIdx = sp + PTR_W'(2);
  end

  assign topWord  = mem[topIdx];
  assign nextWord = mem[nextIdx];

  p_push_dec_r2: assert property (@(negedge clk) disable iff (!rstN)
    ctrl.pushEn |=> sp == $past(sp) - PTR_W'(1));
  p_push_top_r2: assert property (@(negedge clk) disable iff (!rstN)
    ctrl.pushEn |=> topWord == $past(dataIn));
  p_pop_inc_r3: assert property (@(negedge clk) disable iff (!rstN)
    ctrl.popEn |=> sp == $past(sp) + PTR_W'(1));
  p_pop_next_r3: assert property (@(negedge clk) disable iff (!rstN)
    ctrl.popEn |=> topWord == $past(nextWord));
  p_idle_hold_r4: assert property (@(negedge clk) disable iff (!rstN)
    !(ctrl.pushEn || ctrl.popEn) |=> $stable(sp) && $stable(topWord) && $stable(nextWord));
endmodule

// File: rtl/opStack.sv
module opStack
  import opStackPkg::*;
#(
  parameter int WIDTH = 16,
  parameter int PTR_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             en,
  input  logic             dir,
  input  logic [WIDTH-1:0] dataIn,
  output logic [WIDTH-1:0] topWord,
  output logic [WIDTH-1:0] nextWord
);
  stackCtrl_t ctrl;

  opStackCtrl u_ctrl (
    .en   (en),
    .dir  (dir),
    .ctrl (ctrl)
  );

  opStackDatapath #(.WIDTH(WIDTH), .PTR_W(PTR_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .dataIn   (dataIn),
    .topWord  (topWord),
    .nextWord (nextWord)
  );
endmodule

// File: tb/sim_opStack.sv
module sim_opStack;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic en = 1'b0;
  logic dir = 1'b0;
  logic [15:0] dataIn = '0;
  logic [15:0] topWord, nextWord;

  opStack u0 (.clk(clk), .rstN(rstN), .en(en), .dir(dir), .dataIn(dataIn),
              .topWord(topWord), .nextWord(nextWord));

  always #(PERIOD/2) clk = ~clk;

  typedef struct {
    logic [15:0] top;
    logic [15:0] nxt;
    bit chkTop;
    bit chkNxt;
    string req;
  } exp_t;

  exp_t q[$];
  logic [15:0] model [16];
  bit written [16];
  logic [3:0] sp = 4'd15;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  function automatic exp_t snap(string r);
    exp_t e;
    logic [3:0] ti = sp + 4'd1;
    logic [3:0] ni = sp + 4'd2;
    e.top = model[ti]; e.nxt = model[ni];
    e.chkTop = written[ti]; e.chkNxt = written[ni];
    e.req = r;
    return e;
  endfunction

  task automatic compare(exp_t e);
    if (e.chkTop) begin
      checks++;
      if (topWord !== e.top) begin
        fails++;
        $display("FAIL %s topWord actual %h expected %h", e.req, topWord, e.top);
      end
    end
    if (e.chkNxt) begin
      checks++;
      if (nextWord !== e.nxt) begin
        fails++;
        $display("FAIL %s nextWord actual %h expected %h", e.req, nextWord, e.nxt);
      end
    end
  endtask

  // Driver: applies one operation after the rising edge and queues its result
  task automatic step(input logic e, input logic d, input logic [15:0] w, input string r);
    @(posedge clk); #1;
    compare(snap("R8 (no change at rising edge)"));
    en = e; dir = d; dataIn = w;
    if (e && d) begin
      model[sp] = w; written[sp] = 1'b1; sp = sp - 4'd1;
    end else if (e) begin
      sp = sp + 4'd1;
    end
    q.push_back(snap(r));
  endtask

  task automatic doReset();
    @(posedge clk); #1;
    en = 1'b0; rstN = 1'b0;
    sp = 4'd15;
    q.push_back(snap("R1/R6 reset keeps data, pointer at bottom"));
    @(posedge clk); #1;
    rstN = 1'b1;
  endtask

  // Monitor: result is due at the falling edge of the same cycle
  initial begin
    forever begin
      @(negedge clk); #2;
      if (q.size() > 0) compare(q.pop_front());
    end
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) written[i] = 1'b0;
    repeat (2) @(posedge clk);
    #1 rstN = 1'b1;
    // R2: pushes
    step(1, 1, 16'hA001, "R2 push");
    step(1, 1, 16'hA002, "R2 push");
    step(1, 1, 16'hA003, "R2/R5 push dual read");
    // R3: pop
    step(1, 0, 16'hFFFF, "R3 pop");
    // R4: idle with both dir values and changing data
    step(0, 1, 16'h5555, "R4 idle dir=1");
    step(0, 0, 16'h3333, "R4 idle dir=0");
    // R5: fill the array with distinct words
    for (int i = 0; i < 14; i++) step(1, 1, 16'hB000 + 16'(i), "R5 fill");
    // R7: push past the top wraps and overwrites
    step(1, 1, 16'hC0DE, "R7 push wrap");
    step(1, 1, 16'hC0DF, "R7 push wrap");
    step(1, 0, 16'h0, "R3 pop after wrap");
    step(1, 1, 16'hD00D, "R2 push");
    // R1/R6: reset mid-use, data kept
    doReset();
    step(0, 0, 16'h0, "R4 idle after reset");
    // R7: pop below the bottom wraps
    for (int i = 0; i < 18; i++) step(1, 0, 16'h0, "R7 pop wrap");
    step(1, 1, 16'hE111, "R2 push after wrap");
    step(1, 0, 16'h0, "R3 pop");
    @(posedge clk); #1; en = 1'b0;
    repeat (2) @(posedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule